// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit

This block performs lane-parallel addition and subtraction on two 32-bit scalar operands. The operands split either into four independent byte lanes or into two halfword lanes. Each lane applies one of six arithmetic flavours: wrapping, halving or clamping arithmetic, each in a signed or an unsigned form. Two extra halfword operations cross the halves. One adds operand A's high half to operand B's low half in the upper result lane and subtracts in the lower lane. The other subtracts in the upper lane and adds in the lower lane.

Operands come in on a valid/ready stream, and results go out on a valid/ready stream with one register stage between them. The input side accepts a new operation whenever the output stage is empty or is being drained in the same cycle. When the consumer holds ready low, the result register and the flags hold their values, and the input stalls until the result is taken. The wrapping flavours also produce a greater-or-equal flag for each byte. A later selection step can use these flags to pick bytes from one of two values.

Top module: `simd_addsub`

## Requirements
- R1: While rst_n is low, out_valid, result and ge_flags are all zero, and in_ready is 1.
- R2: in_ready equals (not out_valid) or out_ready. An operation accepted at a clock edge (in_valid and in_ready both high) appears on result with out_valid high right after that edge. While out_valid is high and out_ready is low, result and ge_flags hold. With out_ready high and nothing accepted, out_valid falls.
- R3: With size_sel=0 and op_sel=0 (add) or 1 (subtract), byte i of the result is byte i of A plus or minus byte i of B. In the wrapping flavours (flav_sel[1:0]=00) this is taken modulo 256, and flav_sel[2]=1 selects unsigned.
- R4: With size_sel=1 and op_sel 0 or 1, the same rule applies to the two 16-bit lanes, modulo 65536.
- R5: In the halving flavours (flav_sel[1:0]=01), each lane result is bits [W:1] of the exact signed or unsigned sum or difference. Signed lanes shift arithmetically and unsigned lanes shift logically.
- R6: In signed clamping (flav_sel=010), a lane result saturates to -128..127 for bytes and to -32768..32767 for halfwords.
- R7: In unsigned clamping (flav_sel=110), a lane result saturates to 0..255 for bytes and to 0..65535 for halfwords. A difference below zero gives 0.
- R8: op_sel=2 gives result[31:16]=A[31:16]+B[15:0] and result[15:0]=A[15:0]-B[31:16]. op_sel=3 gives result[31:16]=A[31:16]-B[15:0] and result[15:0]=A[15:0]+B[31:16]. Both operations always run at halfword size, whatever size_sel is, and both use the selected flavour.
- R9: In the wrapping flavours, ge_flags bit i belongs to byte i. In halfword size, bits 2h and 2h+1 both carry the flag of halfword lane h. A flag is 1 when the exact signed result is at least zero, when an unsigned add carries out of the lane, or when an unsigned subtract does not borrow.
- R10: In the halving and clamping flavours, ge_flags keeps its previous value.
- R11: The flavour codes 011 and 111 behave as signed and unsigned wrapping, and they update ge_flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Operation can be accepted |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| size_sel | input | 1 | 0 byte lanes, 1 halfword lanes |
| op_sel | input | 2 | 0 add, 1 sub, 2 add-high/sub-low exchange, 3 sub-high/add-low exchange |
| flav_sel | input | 3 | bit 2 unsigned; bits 1:0: 00 wrap, 01 halve, 10 clamp, 11 wrap |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| result | output | 32 | Lane results |
| ge_flags | output | 4 | Per-byte greater-or-equal flags |

## Verification
Directed operands built from 0x00, 0x7F, 0x80 and 0xFF sit exactly on the signed and unsigned overflow edges. They separate correct clamping, wrapping and halving from results that are off by one or have the wrong sign. Random operands mixed from these boundary bytes and free bytes, across all sizes, operations and flavours, check that lanes stay independent and that the exchange operations pair the correct halves. A stall sequence confirms that the output holds under back-pressure and that a waiting input is taken on the draining edge. Flag checks after the halving and clamping operations confirm that ge_flags keeps the value left by the last wrapping operation.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_XAS = 2'd2,
    OP_XSA = 2'd3
  } simd_op_e;

  localparam logic [1:0] KIND_HALVE = 2'b01;
  localparam logic [1:0] KIND_CLAMP = 2'b10;

  function automatic logic flav_wraps(input logic [2:0] fl);
    return (fl[1:0] != KIND_HALVE) && (fl[1:0] != KIND_CLAMP);
  endfunction
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         uns,
  input  logic [1:0]   kind,
  output logic [W-1:0] res,
  output logic         ge
);
  import simd_pkg::*;
  localparam int XW = W + 2;

  logic signed [XW-1:0] xa, xb, full;
  logic signed [XW-1:0] hi_lim, lo_lim;

  always_comb begin
    xa = uns ? {2'b00, a} : {{2{a[W-1]}}, a};
    xb = uns ? {2'b00, b} : {{2{b[W-1]}}, b};
    full = sub ? (xa - xb) : (xa + xb);
    hi_lim = uns ? {2'b00, {W{1'b1}}} : {3'b000, {(W-1){1'b1}}};
    lo_lim = uns ? '0 : {3'b111, {(W-1){1'b0}}};
  end

  always_comb begin
    case (kind)
      KIND_HALVE: res = full[W:1];
      KIND_CLAMP: begin
        if (full > hi_lim)      res = hi_lim[W-1:0];
        else if (full < lo_lim) res = lo_lim[W-1:0];
        else                    res = full[W-1:0];
      end
      default: res = full[W-1:0];
    endcase
  end

  assign ge = (uns && !sub) ? full[W] : !full[XW-1];
endmodule

// File: rtl/simd_core.sv
module simd_core #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            size_half,
  input  logic [1:0]      op,
  input  logic [2:0]      fl,
  output logic [DW-1:0]   res,
  output logic [DW/8-1:0] ge
);
  localparam int BL = DW / 8;
  localparam int HL = DW / 16;

  logic exch, half_eff, uns;
  logic [1:0] kind;
  assign exch     = op[1];
  assign half_eff = size_half | exch;
  assign uns      = fl[2];
  assign kind     = fl[1:0];

  logic [DW-1:0] bres, hres;
  logic [BL-1:0] bge;
  logic [HL-1:0] hge;

  for (genvar i = 0; i < BL; i++) begin : g_byte
    simd_lane #(.W(8)) u_lane (
      .a    (a[i*8 +: 8]),
      .b    (b[i*8 +: 8]),
      .sub  (op[0]),
      .uns  (uns),
      .kind (kind),
      .res  (bres[i*8 +: 8]),
      .ge   (bge[i])
    );
  end

  for (genvar h = 0; h < HL; h++) begin : g_half
    localparam int PAIR = h ^ 1;
    logic [15:0] bsel;
    logic        hsub;
    assign bsel = exch ? b[PAIR*16 +: 16] : b[h*16 +: 16];
    // upper lane of a pair adds for XAS, lower lane subtracts; XSA reversed
    assign hsub = exch ? ((h % 2 == 1) ? op[0] : ~op[0]) : op[0];
    simd_lane #(.W(16)) u_lane (
      .a    (a[h*16 +: 16]),
      .b    (bsel),
      .sub  (hsub),
      .uns  (uns),
      .kind (kind),
      .res  (hres[h*16 +: 16]),
      .ge   (hge[h])
    );
  end

  assign res = half_eff ? hres : bres;

  for (genvar i = 0; i < BL; i++) begin : g_ge
    assign ge[i] = half_eff ? hge[i/2] : bge[i];
  end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub #(
  parameter int DW = 32,
  localparam int GW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          size_sel,
  input  logic [1:0]    op_sel,
  input  logic [2:0]    flav_sel,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] result,
  output logic [GW-1:0] ge_flags
);
  import simd_pkg::*;

  logic [DW-1:0] core_res;
  logic [GW-1:0] core_ge;
  logic          accept;

  simd_core #(.DW(DW)) u_core (
    .a         (opa),
    .b         (opb),
    .size_half (size_sel),
    .op        (op_sel),
    .fl        (flav_sel),
    .res       (core_res),
    .ge        (core_ge)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ge_flags  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      result    <= core_res;
      if (flav_wraps(flav_sel)) ge_flags <= core_ge;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter int DW = 32,
  localparam int GW = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          size_sel,
  input logic [1:0]    op_sel,
  input logic [2:0]    flav_sel,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] result,
  input logic [GW-1:0] ge_flags
);
  logic take, wraps;
  assign take  = in_valid && in_ready;
  assign wraps = (flav_sel[1:0] != 2'b01) && (flav_sel[1:0] != 2'b10);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(ge_flags));

  // R2
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R2
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R2
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take && out_ready |=> !out_valid);

  // R10
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !wraps |=> $stable(ge_flags));

  // R9
  flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && wraps && (size_sel || op_sel[1]) |=> ge_flags[0] == ge_flags[1]);
endmodule

bind simd_addsub simd_addsub_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .size_sel  (size_sel),
  .op_sel    (op_sel),
  .flav_sel  (flav_sel),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .result    (result),
  .ge_flags  (ge_flags)
);

// File: tb/sim_simd_addsub.sv
`timescale 1ns/1ps
module sim_simd_addsub;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] opa = 0, opb = 0;
  logic        size_sel = 0;
  logic [1:0]  op_sel = 0;
  logic [2:0]  flav_sel = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [31:0] result;
  logic [3:0]  ge_flags;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [3:0] ge_model = 0;

  always #2.5 clk = ~clk;

  simd_addsub u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opa(opa), .opb(opb), .size_sel(size_sel), .op_sel(op_sel),
    .flav_sel(flav_sel), .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .ge_flags(ge_flags)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp=<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Reference: returns {ge, result}
  function automatic logic [35:0] model(input logic [31:0] a, input logic [31:0] b,
      input logic sz, input logic [1:0] op, input logic [2:0] fl, input logic [3:0] gprev);
    logic half = sz | op[1];
    int w = half ? 16 : 8;
    int n = half ? 2 : 4;
    int mask = half ? 65535 : 255;
    logic uns = fl[2];
    logic [31:0] res = 0;
    logic [3:0] ge = 0;
    for (int i = 0; i < n; i++) begin
      int bi = op[1] ? (i ^ 1) : i;
      int fa = int'((a >> (i*w)) & 32'(mask));
      int fb = int'((b >> (bi*w)) & 32'(mask));
      logic sub;
      int r, lr;
      logic g;
      if (!uns) begin
        if (fa > mask/2) fa = fa - mask - 1;
        if (fb > mask/2) fb = fb - mask - 1;
      end
      if (op[1]) sub = (i == 1) ? op[0] : !op[0];
      else       sub = op[0];
      r = sub ? fa - fb : fa + fb;
      g = (uns && !sub) ? (r > mask) : (r >= 0);
      case (fl[1:0])
        2'b01: lr = r >>> 1;
        2'b10: begin
          int hi = uns ? mask : mask/2;
          int lo = uns ? 0 : -(mask/2) - 1;
          lr = (r > hi) ? hi : ((r < lo) ? lo : r);
        end
        default: lr = r;
      endcase
      res = res | ((32'(lr) & 32'(mask)) << (i*w));
      if (half) begin ge[2*i] = g; ge[2*i+1] = g; end
      else ge[i] = g;
    end
    if (fl[1:0] == 2'b01 || fl[1:0] == 2'b10) ge = gprev;
    return {ge, res};
  endfunction

  function automatic string req_of(input logic sz, input logic [1:0] op, input logic [2:0] fl);
    if (op[1]) return "R8";
    case (fl[1:0])
      2'b01: return "R5";
      2'b10: return fl[2] ? "R7" : "R6";
      2'b11: return "R11";
      default: return sz ? "R4" : "R3";
    endcase
  endfunction

  task automatic run(input logic [31:0] a, input logic [31:0] b,
      input logic sz, input logic [1:0] op, input logic [2:0] fl);
    logic [35:0] e;
    @(negedge clk);
    opa = a; opb = b; size_sel = sz; op_sel = op; flav_sel = fl; in_valid = 1;
    e = model(a, b, sz, op, fl, ge_model);
    ge_model = e[35:32];
    @(negedge clk);
    in_valid = 0;
    check("R2", {31'd0, out_valid}, 32'd1);
    check(req_of(sz, op, fl), result, e[31:0]);
    check((fl[1:0] == 2'b01 || fl[1:0] == 2'b10) ? "R10" : "R9",
          {28'd0, ge_flags}, {28'd0, e[35:32]});
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      case ($urandom % 6)
        0: v[i*8 +: 8] = 8'h00;
        1: v[i*8 +: 8] = 8'h7F;
        2: v[i*8 +: 8] = 8'h80;
        3: v[i*8 +: 8] = 8'hFF;
        default: v[i*8 +: 8] = 8'($urandom);
      endcase
    end
    return v;
  endfunction

  initial begin
    logic [35:0] ex, ey;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {31'd0, out_valid}, 32'd0);
    check("R1", result, 32'd0);
    check("R1", {28'd0, ge_flags}, 32'd0);
    check("R1", {31'd0, in_ready}, 32'd1);
    rst_n = 1;

    // directed corners
    run(32'h7F7F_7F7F, 32'h0101_0101, 0, 0, 3'b010); // R6 clamps to 7F
    run(32'h8080_8080, 32'h0101_0101, 0, 1, 3'b010); // R6 clamps to 80
    run(32'h7FFF_8000, 32'h0001_0001, 1, 0, 3'b010); // R6 halfword
    run(32'hFFFF_FF00, 32'h0101_0101, 0, 0, 3'b110); // R7 high clamp
    run(32'h0000_0000, 32'h0101_0101, 0, 1, 3'b110); // R7 floor at 0
    run(32'h7F80_FF00, 32'h7F80_FF01, 0, 0, 3'b001); // R5 signed halving
    run(32'h00FF_0080, 32'h01FF_FF80, 0, 1, 3'b101); // R5 unsigned halving
    run(32'hFF7F_8000, 32'h0101_8001, 0, 0, 3'b000); // R3 signed wrap
    run(32'hFF7F_8000, 32'h0101_8001, 0, 1, 3'b100); // R3 unsigned wrap
    run(32'hFFFF_0000, 32'h0001_0001, 1, 0, 3'b100); // R4 carry / R9
    run(32'h1234_5678, 32'h1111_2222, 0, 2, 3'b000); // R8 size ignored
    run(32'h1234_5678, 32'h1111_2222, 1, 3, 3'b100); // R8
    run(32'h8000_7FFF, 32'h0001_8000, 1, 2, 3'b010); // R8 with clamp
    run(32'h0102_0304, 32'h0403_0201, 0, 1, 3'b011); // R11
    run(32'h0102_0304, 32'h0403_0201, 0, 1, 3'b111); // R11
    run(32'hFFFF_FFFF, 32'h0000_0000, 0, 0, 3'b001); // R10 flags kept

    // R2 back-pressure
    @(negedge clk);
    out_ready = 0;
    opa = 32'h0A0B_0C0D; opb = 32'h0102_0304; size_sel = 0; op_sel = 0; flav_sel = 3'b000;
    in_valid = 1;
    ex = model(opa, opb, 0, 0, 3'b000, ge_model);
    ge_model = ex[35:32];
    @(negedge clk);
    opa = 32'h7000_1000; opb = 32'h1000_2000; size_sel = 1; op_sel = 1; flav_sel = 3'b100;
    ey = model(opa, opb, 1, 1, 3'b100, ge_model);
    check("R2", {31'd0, in_ready}, 32'd0);
    repeat (3) @(negedge clk);
    check("R2", result, ex[31:0]);
    check("R2", {31'd0, out_valid}, 32'd1);
    out_ready = 1;
    ge_model = ey[35:32];
    @(negedge clk);
    in_valid = 0;
    check("R2", result, ey[31:0]);
    check("R9", {28'd0, ge_flags}, {28'd0, ey[35:32]});
    @(negedge clk);
    check("R2", {31'd0, out_valid}, 32'd0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [2:0] f = 3'($urandom % 8);
      run(pick(), pick(), 1'($urandom), 2'($urandom), f);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule